// File: doc/BRIEF.md
# Residual-Variable Function Generator

This block produces one Boolean output from an N-bit input vector, where the function is held in a small configuration register that can be loaded at run time. In its main mode the upper N-1 inputs act as the select index of a 2^(N-1)-way selector. Each selector leg carries one of four residual functions of the lowest input: constant 0, the input itself, its inverse, or constant 1. Half the usual table depth is enough to express every N-input function this way.

A second mode reads the same configuration word as a plain 2^N-entry truth table indexed by the whole input vector. Both modes use a word of 2^N bits, so the width of the store does not depend on the mode.

The configuration word and the mode bit are captured together on a single-cycle write strobe. The function output is combinational from the current inputs and the stored configuration. N may be set from 2 to 6.

Top module: `resfn_gen`

## Requirements
- R1: In residual mode the select index is `in_vars[N-1:1]`, with `in_vars[N-1]` as its most significant bit. Leg k uses the 2-bit code held in `cfg_word` bits [2k+1:2k].
- R2: A leg code of 00 drives the output to 0 and a code of 11 drives it to 1, whatever the value of `in_vars[0]`.
- R3: A leg code of 01 drives the output to `in_vars[0]`, and a code of 10 drives it to the inverse of `in_vars[0]`.
- R4: When the stored mode bit is 1 (lookup mode), the output equals bit `in_vars` of the stored word, for all 2^N input values.
- R5: When `cfg_wr` is 1 at a rising clock edge, the whole word and the mode bit are stored, and they govern the output from just after that edge.
- R6: While `cfg_wr` is 0, the stored configuration holds and changes on `cfg_word` or `cfg_lut_mode` have no effect on the output.
- R7: With `rst_n` low at a rising edge, the store clears to all zeros in residual mode, so the output is 0 for every input.
- R8: The output follows a change of `in_vars` within the same clock cycle, with no clock edge needed.
- R9: With N=3, residual mode and the word 8'hCA (leg codes 10, 10, 00, 11 from leg 0 upward), the output is 1 exactly for inputs 0, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Single-cycle load strobe for the configuration |
| cfg_word | input | 2^N | Configuration word to load |
| cfg_lut_mode | input | 1 | Mode to load: 0 residual, 1 lookup |
| in_vars | input | N | Function inputs; bit N-1 is the first variable |
| fn_out | output | 1 | Function output |

## Verification
Uniform words, with every leg at 00, 11, 01 or 10, give a simple output pattern against the lowest input. They separate constant legs from the two variable-following legs and catch a swapped code pair. Random words across every input value expose a wrong select order or leg packing. The same words in lookup mode show whether the mode bit changes how the word is read. The three-input minterm example, words driven without a strobe, and a reset issued over a loaded word check the worked case, the hold behaviour and the clearing of the store.

// File: rtl/rvfg_pkg.sv
// Package: shared residual-code type and its evaluation for the function generator.
// Assumes codes are 2 bits per leg, as listed in the type.
package rvfg_pkg;
    typedef enum logic [1:0] {
        RES_ZERO = 2'b00,
        RES_VAR  = 2'b01,
        RES_INV  = 2'b10,
        RES_ONE  = 2'b11
    } res_code_e;

    // Value of a residual code for a given lowest-input value.
    function automatic logic res_eval(res_code_e code, logic x);
        case (code)
            RES_ZERO: res_eval = 1'b0;
            RES_VAR:  res_eval = x;
            RES_INV:  res_eval = ~x;
            default:  res_eval = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/rvfg_cfg_store.sv
// Configuration store: holds the function word and the mode bit.
// Loads both in full on a single-cycle strobe. Synchronous active-low reset
// clears the word to zero in residual mode.
module rvfg_cfg_store #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] word_in,
    input  logic          mode_in,
    output logic [CW-1:0] word_q,
    output logic          mode_q
);
    // Capture word and mode on the strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mode_q <= 1'b0;
        end else if (wr) begin
            word_q <= word_in;
            mode_q <= mode_in;
        end
    end

    // R5: a strobe stores the presented word and mode.
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (word_q == $past(word_in)) && (mode_q == $past(mode_in)));

    // R6: without a strobe the store holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && $past(rst_n)) |=> $stable(word_q) && $stable(mode_q));
endmodule

// File: rtl/rvfg_leg_bank.sv
// Leg bank: forms the value of every selector leg from the stored word.
// In residual mode each leg decodes its 2-bit code against the lowest input.
// In lookup mode it takes the table bit for the lowest input.
// Assumes leg k occupies word bits [2k+1:2k].
module rvfg_leg_bank
    import rvfg_pkg::*;
#(
    parameter int N = 4,
    localparam int LEGS = 1 << (N - 1),
    localparam int CW = 1 << N
) (
    input  logic [CW-1:0]   word,
    input  logic            lut_mode,
    input  logic            x,
    output logic [LEGS-1:0] legs
);
    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        logic [1:0] pair;
        assign pair = word[2*k+1:2*k];
        // Pick between table bit and residual decode for this leg.
        always_comb begin
            if (lut_mode)
                legs[k] = x ? pair[1] : pair[0];
            else
                legs[k] = res_eval(res_code_e'(pair), x);
        end
    end
endmodule

// File: rtl/rvfg_selector.sv
// Selector: routes one of 2^(N-1) legs to the output, indexed by the upper inputs.
// Purely combinational.
module rvfg_selector #(
    parameter int N = 4,
    localparam int LEGS = 1 << (N - 1)
) (
    input  logic [LEGS-1:0] legs,
    input  logic [N-2:0]    sel,
    output logic            y
);
    // Index the leg vector with the select value.
    always_comb y = legs[sel];
endmodule

// File: rtl/resfn_gen.sv
// Residual-variable function generator top level.
// Computes any N-input function with a 2^(N-1)-way selector whose legs are
// residual functions of in_vars[0]. An alternate mode reads the stored word
// as a 2^N-entry table. Assumes 2 <= N <= 6. The output is combinational.
module resfn_gen
    import rvfg_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = 1 << N,
    localparam int LEGS = 1 << (N - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [CW-1:0] cfg_word,
    input  logic          cfg_lut_mode,
    input  logic [N-1:0]  in_vars,
    output logic          fn_out
);
    logic [CW-1:0]   word_q;
    logic            mode_q;
    logic [LEGS-1:0] legs;

    rvfg_cfg_store #(.CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .word_in(cfg_word),
        .mode_in(cfg_lut_mode), .word_q(word_q), .mode_q(mode_q)
    );

    rvfg_leg_bank #(.N(N)) u_legs (
        .word(word_q), .lut_mode(mode_q), .x(in_vars[0]), .legs(legs)
    );

    rvfg_selector #(.N(N)) u_sel (
        .legs(legs), .sel(in_vars[N-1:1]), .y(fn_out)
    );

    // Code of the currently addressed leg, for the checks below.
    logic [1:0] cur_code;
    assign cur_code = word_q[{in_vars[N-1:1], 1'b0} +: 2];

    // R2: constant codes force the output.
    a_r2_const: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (cur_code == 2'b00 || cur_code == 2'b11)) |-> (fn_out == cur_code[1]));

    // R3: variable codes follow or invert the lowest input.
    a_r3_var: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (cur_code == 2'b01 || cur_code == 2'b10)) |-> (fn_out == (in_vars[0] ^ cur_code[1])));

    // R4: lookup mode reads the addressed table bit.
    a_r4_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (fn_out == word_q[in_vars]));

    // R7: after a reset the output is 0.
    a_r7_reset: assert property (@(posedge clk)
        !rst_n |=> (fn_out == 1'b0) || !rst_n || $past(cfg_wr));
endmodule

// File: tb/resfn_gen_test.sv
// Bench: drives both a four-input and a three-input generator. It compares every
// input value, one per clock, against a truth table that is rebuilt from the
// configuration the bench itself has loaded.
module resfn_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        wr4 = 0, mode4 = 0;
    logic [15:0] word4 = '0;
    logic [3:0]  vars4 = '0;
    logic        out4;
    logic        wr3 = 0, mode3 = 0;
    logic [7:0]  word3 = '0;
    logic [2:0]  vars3 = '0;
    logic        out3;

    resfn_gen #(.N(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr4), .cfg_word(word4),
        .cfg_lut_mode(mode4), .in_vars(vars4), .fn_out(out4)
    );
    resfn_gen #(.N(3)) uut3 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr3), .cfg_word(word3),
        .cfg_lut_mode(mode3), .in_vars(vars3), .fn_out(out3)
    );

    int checks = 0, failures = 0;
    logic [15:0] m_word4 = '0;
    logic        m_mode4 = 0;
    bit finished = 0;

    // Reference value from the requirement text: pair per leg, codes 00/01/10/11.
    function automatic logic ref_val(logic [15:0] w, logic m, int row);
        int leg = row / 2;
        int x = row % 2;
        int code = (w >> (2 * leg)) & 3;
        if (m) return w[row];
        if (code == 0) return 1'b0;
        if (code == 3) return 1'b1;
        if (code == 1) return x[0];
        return ~x[0];
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic load4(logic [15:0] w, logic m);
        @(negedge clk);
        wr4 = 1; word4 = w; mode4 = m;
        @(negedge clk);
        wr4 = 0;
        m_word4 = w; m_mode4 = m;
    endtask

    // One input value per clock; R8: sampled within the cycle, before any edge.
    task automatic sweep4(string req);
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            vars4 = r[3:0];
            #2 check(out4, ref_val(m_word4, m_mode4, r), req);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R7: reset state, output 0 on every input.
        sweep4("R7 reset");
        rst_n = 1;
        // R2: constant legs.
        load4(16'h0000, 0); sweep4("R2 all-zero");
        load4(16'hFFFF, 0); sweep4("R2 all-one");
        // R3: variable and inverse legs.
        load4(16'h5555, 0); sweep4("R3 variable");
        load4(16'hAAAA, 0); sweep4("R3 inverse");
        // R1: leg order and select significance.
        load4(16'b11_10_01_00_00_01_10_11, 0); sweep4("R1 leg order");
        for (int i = 0; i < 4; i++) begin
            load4(16'($urandom), 0); sweep4("R1 random");
        end
        // R4: lookup mode over the whole table.
        load4(16'h8421, 1); sweep4("R4 lookup");
        load4(16'h6996, 1); sweep4("R4 lookup parity");
        // R6: word and mode presented without a strobe have no effect.
        load4(16'h1B4E, 0);
        @(negedge clk); word4 = 16'hE4B1; mode4 = 1;
        sweep4("R6 hold");
        // R5: a strobe takes effect right after its edge.
        @(negedge clk); vars4 = 4'd5;
        wr4 = 1; word4 = 16'h0000; mode4 = 0;
        #2 check(out4, ref_val(m_word4, m_mode4, 5), "R5 before edge");
        @(posedge clk); #1;
        check(out4, 1'b0, "R5 after edge");
        @(negedge clk); wr4 = 0; m_word4 = 16'h0000; m_mode4 = 0;
        // R9: three-input worked example, minterms 0, 2, 6, 7.
        @(negedge clk); wr3 = 1; word3 = 8'hCA; mode3 = 0;
        @(negedge clk); wr3 = 0;
        for (int r = 0; r < 8; r++) begin
            @(negedge clk); vars3 = r[2:0];
            #2 check(out3, (r == 0 || r == 2 || r == 6 || r == 7), "R9 example");
        end
        // R7: reset over a loaded word clears it.
        load4(16'hFFFF, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_word4 = '0; m_mode4 = 0;
        sweep4("R7 reset clears");
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule